// File: doc/BRIEF.md
# LFSR Heartbeat Period Timer

This block measures a long, fixed time interval with very little logic. A binary up-counter and its terminal-count compare are replaced by a maximal-length linear feedback shift register in Galois form. The register advances one state on every clock. When it comes back to its seed value, one full sequence has passed, and the heartbeat level flips.

With the default 20-bit register, one heartbeat half-period is 1,048,575 clocks. At a 3.6864 MHz clock that is about 0.284 s, so a full heartbeat cycle lasts about 0.57 s. The width, feedback mask and seed are parameters. The period is set at elaboration and cannot be changed at run time.

Each advance is a right shift. The lowest stage is the output bit. That bit is ANDed with the feedback mask and XORed into the shifted value. The top stage of the next state is loaded directly from the output bit.

Top module: `lfsr_heartbeat_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register loads the seed (`lfsr_state` equals 1, a single 1 in bit 0), `heartbeat` goes to 0 and `wrap_pulse` goes to 0.
- R2: On each rising edge with `rst` low, the next state is (state >> 1) XOR (state[0] ? POLY : 0). POLY bit W-1 is the constant term and must be set. The default POLY for W=20 is 20'h80004 (x^20 + x^17 + 1).
- R3: Bit W-1 of each new state equals bit 0 of the previous state, with no XOR in that stage.
- R4: With a primitive mask, the register first returns to the seed exactly 2^W - 1 clocks after reset is released, and it does not return to the seed before then.
- R5: `wrap_pulse` is high for exactly one cycle. That is the cycle in which `lfsr_state` has just advanced back to the seed. It is never high in the cycle right after reset.
- R6: `heartbeat` inverts on the same edge that raises `wrap_pulse`, and it holds its value on every other edge.
- R7: `lfsr_state` never becomes all zeros after it starts from the nonzero seed.
- R8: Asserting `rst` in the middle of a period restarts the sequence from the seed, with `heartbeat` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| heartbeat | output | 1 | Level that inverts once per full register sequence |
| wrap_pulse | output | 1 | One-cycle pulse when the register returns to the seed |
| lfsr_state | output | W | Current register contents |

## Verification
The default 20-bit register is too long to cycle through within the allowed run time. The bench therefore runs three widths side by side: a 4-bit register, a 16-bit register and the default 20-bit register.

- **4-bit:** it is checked against a hand-derived sequence table over two periods. This separates correct tap placement and shift direction from variants that produce shorter or different orbits.
- **16-bit:** it is compared with an independent step model on every cycle through one whole period. The first return to the seed must land on exactly clock 65,535, which shows the orbit has no early repeat.
- **20-bit:** it is compared with the model over a long prefix of its sequence and must stay nonzero and free of wraps.

A reset in the middle of a period then checks that the sequence restarts from the seed.

// File: rtl/lfsr_hb_pkg.sv
package lfsr_hb_pkg;
  // Default register width and feedback mask for the heartbeat timer.
  // Bit (W-1) of the mask is the constant term of the polynomial.
  localparam int unsigned HB_W_DEFAULT    = 20;
  localparam logic [19:0] HB_POLY_DEFAULT = 20'h80004;
endpackage

// File: rtl/lfsr_galois_next.sv
module lfsr_galois_next #(
  parameter int unsigned W    = 20,
  parameter logic [W-1:0] POLY = W'(lfsr_hb_pkg::HB_POLY_DEFAULT)
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb = cur[0];

  // Lower stages: shifted bit, XORed with the output bit where the mask has a tap.
  for (genvar i = 0; i < int'(W) - 1; i++) begin : g_stage
    if (POLY[i]) begin : g_tap
      assign nxt[i] = cur[i+1] ^ fb;
    end else begin : g_plain
      assign nxt[i] = cur[i+1];
    end
  end

  // Top stage is fed straight from the output bit (constant term).
  assign nxt[W-1] = fb;
endmodule

// File: rtl/lfsr_hb_core.sv
module lfsr_hb_core #(
  parameter int unsigned  W    = 20,
  parameter logic [W-1:0] POLY = W'(lfsr_hb_pkg::HB_POLY_DEFAULT),
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state_q,
  output logic         wrap_next,
  output logic         wrap_q
);
  logic [W-1:0] state_d;

  lfsr_galois_next #(.W(W), .POLY(POLY)) u_next (
    .cur (state_q),
    .nxt (state_d)
  );

  // Seed match is taken on the next state, so the pulse lines up with the
  // cycle in which the register shows the seed again.
  assign wrap_next = (state_d == SEED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
      wrap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wrap_q  <= wrap_next;
    end
  end

  // R7: a nonzero seed never leads into the lock-up state.
  p_never_zero_r7: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R5: the pulse only appears while the register holds the seed.
  p_wrap_at_seed_r5: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> state_q == SEED);
endmodule

// File: rtl/lfsr_hb_toggle.sv
module lfsr_hb_toggle (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic hb_q
);
  always_ff @(posedge clk) begin
    if (rst)       hb_q <= 1'b0;
    else if (flip) hb_q <= ~hb_q;
  end

  // R6: the level inverts after a flip request.
  p_hb_flip_r6: assert property (@(posedge clk) disable iff (rst)
    flip |=> hb_q != $past(hb_q));

  // R6: the level holds when no flip is requested.
  p_hb_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !flip |=> $stable(hb_q));
endmodule

// File: rtl/lfsr_heartbeat_timer.sv
module lfsr_heartbeat_timer #(
  parameter int unsigned  W    = lfsr_hb_pkg::HB_W_DEFAULT,
  parameter logic [W-1:0] POLY = W'(lfsr_hb_pkg::HB_POLY_DEFAULT),
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic         clk,
  input  logic         rst,
  output logic         heartbeat,
  output logic         wrap_pulse,
  output logic [W-1:0] lfsr_state
);
  logic wrap_next;
  logic armed;

  lfsr_hb_core #(.W(W), .POLY(POLY), .SEED(SEED)) u_core (
    .clk       (clk),
    .rst       (rst),
    .state_q   (lfsr_state),
    .wrap_next (wrap_next),
    .wrap_q    (wrap_pulse)
  );

  lfsr_hb_toggle u_hb (
    .clk  (clk),
    .rst  (rst),
    .flip (wrap_next),
    .hb_q (heartbeat)
  );

  // Marks cycles that follow at least one advancing edge since reset.
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R3: the top stage takes the previous output bit unchanged.
  p_top_feed_r3: assert property (@(posedge clk) disable iff (rst)
    armed |-> lfsr_state[W-1] == $past(lfsr_state[0]));

  // R5: reaching the seed by advancing always raises the pulse.
  p_seed_gives_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && lfsr_state == SEED) |-> wrap_pulse);

  // R5: the pulse lasts a single cycle.
  p_wrap_single_r5: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |=> !wrap_pulse);

  // R6: the heartbeat changes exactly when the pulse is high.
  p_hb_with_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((heartbeat != $past(heartbeat)) == wrap_pulse));
endmodule

// File: tb/lfsr_heartbeat_timer_tb.sv
module lfsr_heartbeat_timer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [3:0]  M4  = 4'h9;
  localparam logic [15:0] M16 = 16'h8805;
  localparam logic [19:0] M20 = 20'h80004;

  // States after 1..15 clocks for the 4-bit register (mask 4'h9, seed 1).
  localparam logic [3:0] SEQ4 [15] = '{4'h9, 4'hD, 4'hF, 4'hE, 4'h7, 4'hA, 4'h5,
                                       4'hB, 4'hC, 4'h6, 4'h3, 4'h8, 4'h4, 4'h2, 4'h1};

  logic        hb4, wp4, hb16, wp16, hb20, wp20;
  logic [3:0]  st4;
  logic [15:0] st16;
  logic [19:0] st20;

  lfsr_heartbeat_timer #(.W(4), .POLY(M4)) u_dut4 (
    .clk(clk), .rst(rst), .heartbeat(hb4), .wrap_pulse(wp4), .lfsr_state(st4));
  lfsr_heartbeat_timer #(.W(16), .POLY(M16)) u_dut16 (
    .clk(clk), .rst(rst), .heartbeat(hb16), .wrap_pulse(wp16), .lfsr_state(st16));
  lfsr_heartbeat_timer u_dut (
    .clk(clk), .rst(rst), .heartbeat(hb20), .wrap_pulse(wp20), .lfsr_state(st20));

  function automatic logic [31:0] gstep(input logic [31:0] s, input logic [31:0] m);
    return (s >> 1) ^ (s[0] ? m : 32'h0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] m4, m16, m20, p4, p16;
    repeat (3) @(negedge clk);
    // R1: reset state on all widths
    chk("R1 state4", st4, 1);   chk("R1 hb4", hb4, 0);   chk("R1 wrap4", wp4, 0);
    chk("R1 state16", st16, 1); chk("R1 hb16", hb16, 0);
    chk("R1 state20", st20, 1); chk("R1 wrap20", wp20, 0);
    rst = 1'b0;
    m4 = 1; m16 = 1; m20 = 1;
    for (int k = 1; k <= 65537; k++) begin
      p4 = m4; p16 = m16;
      m4  = gstep(m4, 32'(M4));
      m16 = gstep(m16, 32'(M16));
      m20 = gstep(m20, 32'(M20));
      @(negedge clk);
      // R2: sequence table and reference step model
      if (k <= 15) chk("R2 table4", st4, SEQ4[k-1]);
      else         chk("R2 model4", st4, m4);
      chk("R2 model16", st16, m16);
      if (k <= 100000) chk("R2 model20", st20, m20);
      // R3: top stage copies the old output bit
      chk("R3 top16", st16[15], p16[0]);
      chk("R3 top4", st4[3], p4[0]);
      // R4/R5: wrap exactly at the period boundary
      chk("R5 wrap4", wp4, (k % 15) == 0);
      chk("R4 wrap16", wp16, k == 65535);
      if (k < 65535) chk("R4 noseed16", st16 == 16'h1, 0);
      chk("R5 wrap20", wp20, 0);
      // R6: heartbeat level by elapsed periods
      chk("R6 hb4", hb4, (k / 15) % 2);
      chk("R6 hb16", hb16, k >= 65535);
      chk("R6 hb20", hb20, 0);
      // R7: no lock-up state
      chk("R7 nonzero20", st20 != 0, 1);
    end
    // R8: reset in mid-period restarts the sequence
    rst = 1'b1;
    @(negedge clk);
    chk("R8 state4", st4, 1); chk("R8 hb16", hb16, 0); chk("R8 state16", st16, 1);
    rst = 1'b0;
    m16 = 1;
    for (int k = 1; k <= 3; k++) begin
      m16 = gstep(m16, 32'(M16));
      @(negedge clk);
      chk("R8 restart4", st4, SEQ4[k-1]);
      chk("R8 restart16", st16, m16);
      chk("R8 nowrap4", wp4, 0);
    end
    summary();
  end
endmodule